// File: doc/BRIEF.md
# Sign-Magnitude End-Around-Carry Adder

This block adds two numbers held in sign-magnitude form. Each operand is a sign bit and a 128-bit unsigned magnitude, and the block returns the sign and the positive magnitude of the signed sum. Operands with equal signs are added. Operands with different signs are subtracted: the second magnitude is complemented, and the carry leaving the top of the word is fed straight back into the bottom. The whole operation takes one carry-propagate pass and no second addition.

The datapath is cut into four 32-bit groups. Each group gives a group generate, a group propagate and two conditional sums, one for carry-in 0 and one for carry-in 1. A ring-shaped carry unit works out the carry into every group, including the wrapped one. The propagate of the lowest group is cut to zero during plain addition, so addition never wraps. The carry out of the top group then does three jobs. It picks the sum for the lowest group during subtraction, it decides whether the chosen sum is inverted into a positive magnitude, and it decides which operand's sign the result carries. In addition mode the same carry is reported as the carry-out of the magnitude sum. The block is purely combinational.

Top module: `eac_sm_adder`

## Requirements
- R1: The operation is a subtraction exactly when `a_sign` and `b_sign` differ, and an addition when they are equal.
- R2: In addition, `r_mag` equals `(a_mag + b_mag) mod 2^128` and `r_carry` equals bit 128 of the full sum.
- R3: In addition, `r_sign` equals the common operand sign.
- R4: In subtraction with `a_mag > b_mag`, `r_mag` equals `a_mag - b_mag` and `r_sign` equals `a_sign`.
- R5: In subtraction with `a_mag < b_mag`, `r_mag` equals `b_mag - a_mag` and `r_sign` equals `b_sign`.
- R6: In subtraction with `a_mag == b_mag`, `r_mag` is zero and `r_sign` equals `a_sign`.
- R7: `r_carry` is 0 in every subtraction.
- R8: Carries and borrows cross all three 32-bit group boundaries correctly. This includes a chain running through all four groups, for example all-ones plus one in addition, or `2^96` minus one in subtraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| a_mag | input | 128 | Magnitude of operand A |
| b_sign | input | 1 | Sign of operand B (1 = negative) |
| b_mag | input | 128 | Magnitude of operand B |
| r_sign | output | 1 | Sign of the result |
| r_mag | output | 128 | Magnitude of the result |
| r_carry | output | 1 | Carry-out of the magnitude sum in addition; 0 in subtraction |

## Verification
The assertions are immediate checks on a combinational block. They take for granted only that every input bit is 0 or 1, and each check is skipped while any input is unknown. The bench keeps to this by driving every input with a defined value from time zero, including the all-zero first vector.

The stimulus reaches the sign and carry corners through directed magnitudes applied in all four sign combinations:
- zero operands
- equal magnitudes
- all-ones operands
- values that make a carry or borrow travel across every group boundary

Random magnitudes are added on top of these directed cases.

// File: rtl/eac_pkg.sv
package eac_pkg;
  localparam int unsigned EAC_WIDTH  = 128;
  localparam int unsigned EAC_GROUPS = 4;

  // Result magnitude: invert the selected sum when a subtraction
  // wrapped no carry (second magnitude was larger).
  function automatic logic [EAC_WIDTH-1:0] fix_mag(input logic [EAC_WIDTH-1:0] sel_sum,
                                                   input logic sub, input logic top_c);
    return (sub && !top_c) ? ~sel_sum : sel_sum;
  endfunction

  // Result sign: first operand's sign when the top carry is set.
  function automatic logic pick_sign(input logic sa, input logic sb, input logic top_c);
    return top_c ? sa : sb;
  endfunction
endpackage

// File: rtl/eac_group.sv
module eac_group #(
  parameter int unsigned GW = 32
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  output logic          g,
  output logic          p,
  output logic [GW-1:0] s0,
  output logic [GW-1:0] s1
);
  logic [GW:0] sum0;
  logic [GW:0] sum1;

  always_comb begin
    sum0 = {1'b0, a} + {1'b0, b};
    sum1 = sum0 + {{GW{1'b0}}, 1'b1};
  end

  assign g  = sum0[GW];
  assign p  = &(a ^ b);
  assign s0 = sum0[GW-1:0];
  assign s1 = sum1[GW-1:0];

  always_comb begin
    if (!$isunknown({a, b})) begin
      AST_GRP_GEN_PROP: assert (!(g && p)) else $error("group g and p both set"); // R8
      AST_GRP_SUM_STEP: assert (s1 == s0 + {{(GW-1){1'b0}}, 1'b1}) else $error("s1 != s0+1"); // R8
    end
  end
endmodule

// File: rtl/eac_carry_ring.sv
module eac_carry_ring #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         sub,
  output logic [N-1:0] cin   // cin[0] is the wrapped top carry
);
  logic [N-1:0] pg;  // propagates with the lowest one gated

  // Scan groups downward from k-1, wrapping through the top group.
  function automatic logic wrap_carry(input logic [N-1:0] gg, input logic [N-1:0] pp,
                                      input int k);
    logic acc;
    logic run;
    acc = 1'b0;
    run = 1'b1;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = (k + int'(N) - 1 - i) % int'(N);
      acc = acc | (run & gg[idx]);
      run = run & pp[idx];
    end
    return acc | run;
  endfunction

  always_comb begin
    pg    = p;
    pg[0] = p[0] & sub;
  end

  for (genvar k = 0; k < N; k++) begin : g_cin
    assign cin[k] = wrap_carry(g, pg, k);
  end

  always_comb begin
    if (!$isunknown({g, p, sub})) begin
      AST_ADD_NO_WRAP: assert (sub || (cin[1] == g[0])) else $error("addition wrapped"); // R2
      AST_FULL_PROP_WRAP: assert (!(sub && (&p)) || (&cin)) else $error("full propagate lost"); // R6
    end
  end
endmodule

// File: rtl/eac_sm_adder.sv
module eac_sm_adder
  import eac_pkg::*;
#(
  parameter int unsigned WIDTH  = EAC_WIDTH,
  parameter int unsigned GROUPS = EAC_GROUPS
) (
  input  logic             a_sign,
  input  logic [WIDTH-1:0] a_mag,
  input  logic             b_sign,
  input  logic [WIDTH-1:0] b_mag,
  output logic             r_sign,
  output logic [WIDTH-1:0] r_mag,
  output logic             r_carry
);
  localparam int unsigned GW = WIDTH / GROUPS;

  logic              op_sub;
  logic [WIDTH-1:0]  b_eff;
  logic [GROUPS-1:0] grp_g;
  logic [GROUPS-1:0] grp_p;
  logic [GROUPS-1:0] grp_cin;
  logic [GROUPS-1:0] grp_sel;
  logic [WIDTH-1:0]  sum0;
  logic [WIDTH-1:0]  sum1;
  logic [WIDTH-1:0]  sel_sum;
  logic              top_c;

  assign op_sub = a_sign ^ b_sign;
  assign b_eff  = op_sub ? ~b_mag : b_mag;

  for (genvar k = 0; k < GROUPS; k++) begin : g_grp
    eac_group #(.GW(GW)) u_grp (
      .a  (a_mag[k*GW +: GW]),
      .b  (b_eff[k*GW +: GW]),
      .g  (grp_g[k]),
      .p  (grp_p[k]),
      .s0 (sum0[k*GW +: GW]),
      .s1 (sum1[k*GW +: GW])
    );
    if (k == 0) begin : g_low
      assign grp_sel[k] = grp_cin[0] & op_sub;
    end else begin : g_up
      assign grp_sel[k] = grp_cin[k];
    end
    assign sel_sum[k*GW +: GW] = grp_sel[k] ? sum1[k*GW +: GW] : sum0[k*GW +: GW];
  end

  eac_carry_ring #(.N(GROUPS)) u_ring (
    .g   (grp_g),
    .p   (grp_p),
    .sub (op_sub),
    .cin (grp_cin)
  );

  assign top_c   = grp_cin[0];
  assign r_mag   = fix_mag(sel_sum, op_sub, top_c);
  assign r_sign  = pick_sign(a_sign, b_sign, top_c);
  assign r_carry = top_c & ~op_sub;

  always_comb begin
    if (!$isunknown({a_sign, a_mag, b_sign, b_mag})) begin
      AST_CARRY_ADD_ONLY: assert (!(r_carry && (a_sign != b_sign))) else $error("carry in subtract"); // R7
      AST_ADD_SIGN: assert ((a_sign != b_sign) || (r_sign == a_sign)) else $error("add sign"); // R3
      AST_EQ_ZERO: assert (!((a_sign != b_sign) && (a_mag == b_mag)) || (r_mag == '0 && r_sign == a_sign))
        else $error("equal subtract"); // R6
      AST_SUB_BOUND: assert ((a_sign == b_sign) || (r_mag <= ((a_mag > b_mag) ? a_mag : b_mag)))
        else $error("subtract magnitude too large"); // R5
    end
  end
endmodule

// File: tb/sim_eac_sm_adder.sv
module sim_eac_sm_adder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic         a_sign = 1'b0, b_sign = 1'b0;
  logic [127:0] a_mag = '0, b_mag = '0;
  logic         r_sign;
  logic [127:0] r_mag;
  logic         r_carry;

  eac_sm_adder u0 (
    .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
    .r_sign(r_sign), .r_mag(r_mag), .r_carry(r_carry)
  );

  typedef struct {
    logic         sgn;
    logic [127:0] mag;
    logic         cy;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit driving = 1'b1;
  bit finished = 1'b0;

  task automatic check_bit(string tag, string what, logic act, logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, expv);
    end
  endtask

  // Reference sign-magnitude model, written from the requirements.
  task automatic drive(logic sa, logic [127:0] ma, logic sb, logic [127:0] mb);
    exp_t e;
    logic [128:0] full;
    @(posedge clk);
    #1;
    a_sign = sa; a_mag = ma; b_sign = sb; b_mag = mb;
    if (sa == sb) begin
      full  = {1'b0, ma} + {1'b0, mb};
      e.mag = full[127:0]; e.cy = full[128]; e.sgn = sa; e.tag = "R1 R2 R3";
    end else if (ma > mb) begin
      e.mag = ma - mb; e.cy = 1'b0; e.sgn = sa; e.tag = "R1 R4 R7";
    end else if (ma < mb) begin
      e.mag = mb - ma; e.cy = 1'b0; e.sgn = sb; e.tag = "R1 R5 R7";
    end else begin
      e.mag = '0; e.cy = 1'b0; e.sgn = sa; e.tag = "R6 R7";
    end
    exp_q.push_back(e);
  endtask

  task automatic drive_tagged(logic sa, logic [127:0] ma, logic sb, logic [127:0] mb);
    drive(sa, ma, sb, mb);
    exp_q[$].tag = {exp_q[$].tag, " R8"};
  endtask

  // Monitor: compare away from the driving edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if (r_mag !== e.mag) begin
          bad++;
          $display("FAIL %s magnitude actual=%h expected=%h", e.tag, r_mag, e.mag);
        end
        check_bit(e.tag, "sign", r_sign, e.sgn);
        check_bit(e.tag, "carry", r_carry, e.cy);
      end
    end
  end

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    logic [127:0] ones;
    ones = '1;
    // Idle state with all-zero inputs: zero result, positive, no carry (R2)
    drive(1'b0, '0, 1'b0, '0);
    for (int s = 0; s < 4; s++) begin
      logic sa, sb;
      logic [127:0] v;
      sa = s[1]; sb = s[0];
      v = rnd128();
      drive(sa, '0, sb, '0);
      drive(sa, v, sb, v);                 // R6 equal magnitudes
      drive(sa, ones, sb, ones);
      drive(sa, '0, sb, v);
      drive(sa, v, sb, '0);
      drive_tagged(sa, ones, sb, 128'd1);  // R8 full chain
      drive_tagged(sa, 128'd1, sb, ones);
      drive_tagged(sa, 128'h1 << 96, sb, 128'd1);
      drive_tagged(sa, 128'd1, sb, 128'h1 << 96);
      drive_tagged(sa, 128'hFFFF_FFFF, sb, 128'd1);
      drive_tagged(sa, 128'h1_0000_0000_0000_0000, sb, 128'h1);
      drive(sa, v, sb, v + 128'd1);        // R5 off by one
      drive(sa, v + 128'd1, sb, v);        // R4 off by one
    end
    for (int i = 0; i < 400; i++) begin
      drive($urandom_range(0, 1) == 1, rnd128(), $urandom_range(0, 1) == 1, rnd128());
    end
    repeat (3) @(posedge clk);
    driving = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule